// File: doc/BRIEF.md
# Single-Accumulator Eight-Opcode Processor Core

This block is a small processor core built around one 12-bit working register, the accumulator. Every arithmetic and logic result lands in the accumulator. A 9-bit program counter walks through a word-addressed external memory. Each instruction word carries a 3-bit opcode and a 9-bit direct address. Eight opcodes cover the following:

- bitwise AND and addition against memory
- increment of a memory word with a conditional skip
- a store that clears the accumulator afterwards
- a subroutine call that leaves its return point in memory
- a plain jump
- a device transfer
- a group of accumulator micro-operations that includes halt

The core talks to a synchronous single-port memory whose read data appears one clock after the read request. A one-cycle strobe, with a device code and the accumulator value, serves simple I/O. The accumulator and program counter are brought out for debug. The sequencer spends a fetch, an instruction-latch and an execute cycle on every instruction. Instructions that need a memory operand take a fourth cycle.

Top module: `acc_cpu`

## Requirements
- R1: While `rst_n` is low, `dbg_ac` and `dbg_pc` read 0, `halted` is 0 and `mem_wr` is 0; after release, execution starts at address 0.
- R2: An instruction word holds the opcode in bits [11:9] (0 AND, 1 ADD, 2 ISZ, 3 DCA, 4 JMS, 5 JMP, 6 IOT, 7 OPR) and a direct address in bits [8:0]; non-branching instructions advance the PC by one.
- R3: AND sets the accumulator to its bitwise AND with the addressed memory word.
- R4: ADD sets the accumulator to its sum with the addressed memory word, modulo 4096.
- R5: ISZ writes the addressed word plus one (modulo 4096) back to memory and advances the PC by two when that result is zero, otherwise by one.
- R6: DCA writes the accumulator to the addressed word and leaves the accumulator at zero.
- R7: JMS writes the address of the following instruction to the addressed word and continues at the addressed word plus one.
- R8: JMP continues execution at the addressed word.
- R9: OPR applies its low-order bits in this order: bit 0 clears the accumulator, then bit 1 complements it, then bit 2 increments it (modulo 4096); bit 3 halts.
- R10: IOT raises `io_strobe` for exactly one cycle with `io_code` equal to instruction bits [8:3] and `io_out` equal to the accumulator; when instruction bit 0 is set the accumulator is loaded from `io_in`.
- R11: After a halt the core keeps `halted` high, holds PC (pointing one past the halt word) and the accumulator, and writes no memory until reset.
- R12: Read data is taken one cycle after `mem_rd`; `mem_rd` and `mem_wr` are never asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_addr | output | 9 | Memory word address |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write enable |
| mem_wdata | output | 12 | Memory write data |
| mem_rdata | input | 12 | Memory read data, valid one cycle after `mem_rd` |
| io_strobe | output | 1 | One-cycle device transfer strobe |
| io_code | output | 6 | Device code during the strobe |
| io_out | output | 12 | Accumulator value offered to the device |
| io_in | input | 12 | Device data loaded on a read transfer |
| halted | output | 1 | Core has executed a halt |
| dbg_ac | output | 12 | Accumulator value |
| dbg_pc | output | 9 | Program counter value |

## Verification
Every pairing of eight operand values is run through short AND and ADD programs. The values are zero, one, all ones, alternating bit patterns and sign-boundary values, and together they separate a carry-dropping or truncating adder from a correct one. The same values are swept against all eight combinations of the clear, complement and increment bits, which exposes a wrong micro-operation order. Increment-and-skip runs on values on either side of the wrap to zero, so a skip taken on the wrong condition changes the final accumulator. Call, jump, device-transfer and halt programs check the link word, the landing address, the strobe count and the frozen state after a halt.

// File: rtl/acc_cpu_pkg.sv
// Package acc_cpu_pkg
// Shared widths, opcode numbering, sequencer states and datapath select codes
// for the accumulator core. Assumes a 3-bit opcode field at the top of a word.
package acc_cpu_pkg;

    localparam int WORD_W = 12;
    localparam int OP_W   = 3;
    localparam int ADDR_W = WORD_W - OP_W;

    // Operate-group bit positions within the address field
    localparam int OPR_CLR_BIT = 0;
    localparam int OPR_CMP_BIT = 1;
    localparam int OPR_INC_BIT = 2;
    localparam int OPR_HLT_BIT = 3;

    // Device-transfer field layout
    localparam int IOT_RD_BIT   = 0;
    localparam int IOT_CODE_LSB = 3;
    localparam int IOT_CODE_W   = ADDR_W - IOT_CODE_LSB;

    typedef enum logic [OP_W-1:0] {
        OP_AND = 3'd0,
        OP_ADD = 3'd1,
        OP_ISZ = 3'd2,
        OP_DCA = 3'd3,
        OP_JMS = 3'd4,
        OP_JMP = 3'd5,
        OP_IOT = 3'd6,
        OP_OPR = 3'd7
    } opcode_e;

    typedef enum logic [2:0] {
        ST_FETCH  = 3'd0,
        ST_LATCH  = 3'd1,
        ST_EXEC   = 3'd2,
        ST_OPND   = 3'd3,
        ST_HALT   = 3'd4
    } state_e;

    typedef enum logic [2:0] {
        AC_HOLD = 3'd0,
        AC_AND  = 3'd1,
        AC_ADD  = 3'd2,
        AC_ZERO = 3'd3,
        AC_OPR  = 3'd4,
        AC_IN   = 3'd5
    } ac_src_e;

    typedef enum logic [2:0] {
        PC_HOLD = 3'd0,
        PC_STEP = 3'd1,
        PC_SKIP = 3'd2,
        PC_CALL = 3'd3,
        PC_JUMP = 3'd4
    } pc_src_e;

    typedef enum logic [1:0] {
        WD_AC   = 2'd0,
        WD_LINK = 2'd1,
        WD_INC  = 2'd2
    } wd_src_e;

endpackage

// File: rtl/acc_alu.sv
// Module acc_alu
// Purely combinational result logic for the accumulator core: AND and add
// against a memory word, memory increment with zero detect, and the ordered
// operate chain (clear, then complement, then increment). All results wrap
// modulo 2**W. Assumes the caller selects which result is used.
module acc_alu
    import acc_cpu_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic [W-1:0] ac,
    input  logic [W-1:0] mem_val,
    input  logic         opr_clr,
    input  logic         opr_cmp,
    input  logic         opr_inc,
    output logic [W-1:0] and_res,
    output logic [W-1:0] add_res,
    output logic [W-1:0] mem_inc,
    output logic         mem_inc_zero,
    output logic [W-1:0] opr_res
);

    // Two-operand results against memory
    always_comb begin
        and_res = ac & mem_val;
        add_res = ac + mem_val;
    end

    // Memory increment for increment-and-skip, with wrap-to-zero flag
    always_comb begin
        mem_inc      = mem_val + W'(1);
        mem_inc_zero = (mem_inc == '0);
    end

    // Operate chain applied in fixed order
    always_comb begin
        logic [W-1:0] v;
        v = ac;
        if (opr_clr) v = '0;
        if (opr_cmp) v = ~v;
        if (opr_inc) v = v + W'(1);
        opr_res = v;
    end

endmodule

// File: rtl/acc_seq.sv
// Module acc_seq
// Instruction sequencer. Walks fetch, latch and execute, plus an operand cycle
// for opcodes that read memory, and parks in a halt state. It produces the
// memory strobes and the select codes for accumulator, PC and write data.
// Assumes memory returns read data one cycle after the read request.
module acc_seq
    import acc_cpu_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  opcode_e op,
    input  logic    opr_halt,
    input  logic    iot_rd,
    input  logic    mem_inc_zero,
    output state_e  state,
    output logic    mem_rd,
    output logic    mem_wr,
    output logic    addr_from_ir,
    output logic    ir_load,
    output logic    io_strobe,
    output wd_src_e wd_sel,
    output ac_src_e ac_sel,
    output pc_src_e pc_sel
);

    state_e state_nx;

    // State register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_FETCH;
        else        state <= state_nx;
    end

    // Next state and per-state control outputs
    always_comb begin
        state_nx     = state;
        mem_rd       = 1'b0;
        mem_wr       = 1'b0;
        addr_from_ir = 1'b0;
        ir_load      = 1'b0;
        io_strobe    = 1'b0;
        wd_sel       = WD_AC;
        ac_sel       = AC_HOLD;
        pc_sel       = PC_HOLD;
        case (state)
            ST_FETCH: begin
                mem_rd   = 1'b1;
                state_nx = ST_LATCH;
            end
            ST_LATCH: begin
                ir_load  = 1'b1;
                state_nx = ST_EXEC;
            end
            ST_EXEC: begin
                state_nx = ST_FETCH;
                case (op)
                    OP_AND, OP_ADD, OP_ISZ: begin
                        mem_rd       = 1'b1;
                        addr_from_ir = 1'b1;
                        state_nx     = ST_OPND;
                    end
                    OP_DCA: begin
                        mem_wr       = 1'b1;
                        addr_from_ir = 1'b1;
                        wd_sel       = WD_AC;
                        ac_sel       = AC_ZERO;
                        pc_sel       = PC_STEP;
                    end
                    OP_JMS: begin
                        mem_wr       = 1'b1;
                        addr_from_ir = 1'b1;
                        wd_sel       = WD_LINK;
                        pc_sel       = PC_CALL;
                    end
                    OP_JMP: begin
                        pc_sel = PC_JUMP;
                    end
                    OP_IOT: begin
                        io_strobe = 1'b1;
                        ac_sel    = iot_rd ? AC_IN : AC_HOLD;
                        pc_sel    = PC_STEP;
                    end
                    OP_OPR: begin
                        ac_sel = AC_OPR;
                        pc_sel = PC_STEP;
                        if (opr_halt) state_nx = ST_HALT;
                    end
                    default: state_nx = ST_FETCH;
                endcase
            end
            ST_OPND: begin
                state_nx = ST_FETCH;
                case (op)
                    OP_AND: begin
                        ac_sel = AC_AND;
                        pc_sel = PC_STEP;
                    end
                    OP_ADD: begin
                        ac_sel = AC_ADD;
                        pc_sel = PC_STEP;
                    end
                    OP_ISZ: begin
                        mem_wr       = 1'b1;
                        addr_from_ir = 1'b1;
                        wd_sel       = WD_INC;
                        pc_sel       = mem_inc_zero ? PC_SKIP : PC_STEP;
                    end
                    default: pc_sel = PC_STEP;
                endcase
            end
            ST_HALT: state_nx = ST_HALT;
            default: state_nx = ST_FETCH;
        endcase
    end

endmodule

// File: rtl/acc_cpu.sv
// Module acc_cpu
// Top of the accumulator core: holds the accumulator, program counter and
// instruction register, muxes the memory address and write data, and hooks up
// the sequencer and result logic. Assumes an external synchronous memory with
// one-cycle read latency and a device that samples io_out on io_strobe.
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W = WORD_W,
    parameter int OPC_W  = OP_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    output logic [DATA_W-OPC_W-1:0]   mem_addr,
    output logic                      mem_rd,
    output logic                      mem_wr,
    output logic [DATA_W-1:0]         mem_wdata,
    input  logic [DATA_W-1:0]         mem_rdata,
    output logic                      io_strobe,
    output logic [DATA_W-OPC_W-IOT_CODE_LSB-1:0] io_code,
    output logic [DATA_W-1:0]         io_out,
    input  logic [DATA_W-1:0]         io_in,
    output logic                      halted,
    output logic [DATA_W-1:0]         dbg_ac,
    output logic [DATA_W-OPC_W-1:0]   dbg_pc
);

    localparam int AW = DATA_W - OPC_W;

    logic [DATA_W-1:0] ac;
    logic [AW-1:0]     pc;
    logic [DATA_W-1:0] ir;
    opcode_e           op;
    logic [AW-1:0]     ir_addr;
    state_e            state;
    logic              addr_from_ir;
    logic              ir_load;
    wd_src_e           wd_sel;
    ac_src_e           ac_sel;
    pc_src_e           pc_sel;
    logic [DATA_W-1:0] and_res;
    logic [DATA_W-1:0] add_res;
    logic [DATA_W-1:0] mem_inc;
    logic              mem_inc_zero;
    logic [DATA_W-1:0] opr_res;
    logic [AW-1:0]     pc_next_seq;

    // Instruction field split
    always_comb begin
        op      = opcode_e'(ir[DATA_W-1 -: OPC_W]);
        ir_addr = ir[AW-1:0];
    end

    acc_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .op           (op),
        .opr_halt     (ir[OPR_HLT_BIT]),
        .iot_rd       (ir[IOT_RD_BIT]),
        .mem_inc_zero (mem_inc_zero),
        .state        (state),
        .mem_rd       (mem_rd),
        .mem_wr       (mem_wr),
        .addr_from_ir (addr_from_ir),
        .ir_load      (ir_load),
        .io_strobe    (io_strobe),
        .wd_sel       (wd_sel),
        .ac_sel       (ac_sel),
        .pc_sel       (pc_sel)
    );

    acc_alu #(.W(DATA_W)) u_alu (
        .ac           (ac),
        .mem_val      (mem_rdata),
        .opr_clr      (ir[OPR_CLR_BIT]),
        .opr_cmp      (ir[OPR_CMP_BIT]),
        .opr_inc      (ir[OPR_INC_BIT]),
        .and_res      (and_res),
        .add_res      (add_res),
        .mem_inc      (mem_inc),
        .mem_inc_zero (mem_inc_zero),
        .opr_res      (opr_res)
    );

    // Address of the instruction after the current one
    always_comb pc_next_seq = pc + AW'(1);

    // Memory address and write-data selection
    always_comb begin
        mem_addr = addr_from_ir ? ir_addr : pc;
        case (wd_sel)
            WD_LINK: mem_wdata = DATA_W'(pc_next_seq);
            WD_INC:  mem_wdata = mem_inc;
            default: mem_wdata = ac;
        endcase
    end

    // Instruction register capture after fetch
    always_ff @(posedge clk) begin
        if (!rst_n)       ir <= '0;
        else if (ir_load) ir <= mem_rdata;
    end

    // Accumulator update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ac <= '0;
        end else begin
            case (ac_sel)
                AC_AND:  ac <= and_res;
                AC_ADD:  ac <= add_res;
                AC_ZERO: ac <= '0;
                AC_OPR:  ac <= opr_res;
                AC_IN:   ac <= io_in;
                default: ac <= ac;
            endcase
        end
    end

    // Program counter update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= '0;
        end else begin
            case (pc_sel)
                PC_STEP: pc <= pc_next_seq;
                PC_SKIP: pc <= pc + AW'(2);
                PC_CALL: pc <= ir_addr + AW'(1);
                PC_JUMP: pc <= ir_addr;
                default: pc <= pc;
            endcase
        end
    end

    // Observation and device outputs
    always_comb begin
        halted  = (state == ST_HALT);
        dbg_ac  = ac;
        dbg_pc  = pc;
        io_out  = ac;
        io_code = ir[AW-1:IOT_CODE_LSB];
    end

endmodule

// Module acc_cpu_chk
// Temporal checks on the accumulator core, attached through bind. Observes
// ports plus the sequencer state and instruction register.
module acc_cpu_chk
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W = WORD_W,
    parameter int AW     = ADDR_W
) (
    input logic              clk,
    input logic              rst_n,
    input state_e            state,
    input logic [DATA_W-1:0] ir,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [DATA_W-1:0] mem_rdata,
    input logic              io_strobe,
    input logic              halted,
    input logic [DATA_W-1:0] dbg_ac,
    input logic [AW-1:0]     dbg_pc
);

    logic [AW-1:0] call_target;
    logic [AW-1:0] skip_target;
    logic          in_exec_op_dca;
    logic          in_exec_op_jms;
    logic          isz_wraps;

    // Expected values derived from observed state
    always_comb begin
        call_target    = AW'(ir[AW-1:0] + AW'(1));
        skip_target    = AW'(dbg_pc + AW'(2));
        in_exec_op_dca = (state == ST_EXEC) && (ir[DATA_W-1 -: 3] == OP_DCA);
        in_exec_op_jms = (state == ST_EXEC) && (ir[DATA_W-1 -: 3] == OP_JMS);
        isz_wraps      = (state == ST_OPND) && (ir[DATA_W-1 -: 3] == OP_ISZ) && (mem_rdata == '1);
    end

    // R12
    rw_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R10
    io_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_strobe |=> !io_strobe);

    // R11
    halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted && $stable(dbg_pc) && $stable(dbg_ac) && !mem_wr);

    // R6
    store_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_exec_op_dca |=> (dbg_ac == '0));

    // R7
    call_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_exec_op_jms |=> (dbg_pc == $past(call_target)));

    // R5
    wrap_skips_chk: assert property (@(posedge clk) disable iff (!rst_n)
        isz_wraps |=> (dbg_pc == $past(skip_target)));

endmodule

bind acc_cpu acc_cpu_chk #(.DATA_W(DATA_W), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .ir        (ir),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_rdata (mem_rdata),
    .io_strobe (io_strobe),
    .halted    (halted),
    .dbg_ac    (dbg_ac),
    .dbg_pc    (dbg_pc)
);

// File: tb/acc_cpu_test.sv
// Bench for acc_cpu: runs short programs from a bench-owned memory model and
// compares accumulator, PC, memory and device activity with values computed here.
module acc_cpu_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  mem_addr;
    logic        mem_rd, mem_wr;
    logic [11:0] mem_wdata;
    logic [11:0] mem_rdata;
    logic        io_strobe;
    logic [5:0]  io_code;
    logic [11:0] io_out;
    logic [11:0] io_in = 12'h5A5;
    logic        halted;
    logic [11:0] dbg_ac;
    logic [8:0]  dbg_pc;

    logic [11:0] mem [512];
    logic        ld_en = 1'b0, ld_clr = 1'b0;
    logic [8:0]  ld_addr = '0;
    logic [11:0] ld_data = '0;

    int n_chk = 0, n_err = 0;
    int strobes = 0, both_rw = 0, halt_writes = 0;
    logic [5:0]  last_code;
    logic [11:0] last_out;
    bit done = 0;

    always #10 clk = ~clk;

    acc_cpu uut (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .io_strobe(io_strobe), .io_code(io_code), .io_out(io_out), .io_in(io_in),
        .halted(halted), .dbg_ac(dbg_ac), .dbg_pc(dbg_pc)
    );

    // Synchronous memory model with bench load port
    always @(posedge clk) begin
        if (ld_clr) begin
            for (int i = 0; i < 512; i++) mem[i] <= '0;
        end else if (ld_en) begin
            mem[ld_addr] <= ld_data;
        end else if (mem_wr) begin
            mem[mem_addr] <= mem_wdata;
        end
        if (mem_rd) mem_rdata <= mem[mem_addr];
    end

    // Activity monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (io_strobe) begin
                strobes++;
                last_code = io_code;
                last_out  = io_out;
            end
            if (mem_rd && mem_wr) both_rw++;
            if (halted && mem_wr) halt_writes++;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [11:0] ins(input int op, input int a);
        return {op[2:0], a[8:0]};
    endfunction

    task automatic begin_prog();
        @(negedge clk);
        rst_n = 1'b0;
        ld_clr = 1'b1;
        @(negedge clk);
        ld_clr = 1'b0;
        strobes = 0;
        halt_writes = 0;
    endtask

    task automatic put(input int a, input logic [11:0] d);
        ld_en = 1'b1;
        ld_addr = a[8:0];
        ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic run(input string req);
        int cyc;
        rst_n = 1'b1;
        cyc = 0;
        while (!halted && cyc < 1000) begin
            @(negedge clk);
            cyc++;
        end
        chk(req, "program reached halt", int'(halted), 1);
    endtask

    logic [11:0] vals [8] = '{12'h000, 12'h001, 12'h7FF, 12'h800,
                              12'hFFF, 12'h555, 12'hAAA, 12'h123};

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "ac in reset", int'(dbg_ac), 0);
        chk("R1", "pc in reset", int'(dbg_pc), 0);
        chk("R1", "halted in reset", int'(halted), 0);
        chk("R1", "write in reset", int'(mem_wr), 0);

        // R3 R4 R6: AND and ADD sweeps, result stored with DCA
        for (int op = 0; op < 2; op++) begin
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    logic [11:0] e;
                    begin_prog();
                    put(0, ins(7, 1));
                    put(1, ins(1, 100));
                    put(2, ins(op, 101));
                    put(3, ins(3, 102));
                    put(4, ins(7, 8));
                    put(100, vals[i]);
                    put(101, vals[j]);
                    e = (op == 0) ? (vals[i] & vals[j]) : (vals[i] + vals[j]);
                    run(op == 0 ? "R3" : "R4");
                    chk(op == 0 ? "R3" : "R4", "stored result", int'(mem[102]), int'(e));
                    chk("R6", "ac after store", int'(dbg_ac), 0);
                    chk("R2", "pc after straight line", int'(dbg_pc), 5);
                end
            end
        end

        // R9: operate bits swept against every value
        for (int i = 0; i < 8; i++) begin
            for (int m = 0; m < 8; m++) begin
                logic [11:0] e;
                begin_prog();
                put(0, ins(7, 1));
                put(1, ins(1, 100));
                put(2, ins(7, m));
                put(3, ins(7, 8));
                put(100, vals[i]);
                e = vals[i];
                if (m[0]) e = '0;
                if (m[1]) e = ~e;
                if (m[2]) e = e + 12'd1;
                run("R9");
                chk("R9", "operate result", int'(dbg_ac), int'(e));
            end
        end

        // R5: increment and skip across the wrap
        for (int i = 0; i < 8; i++) begin
            logic [11:0] inc;
            begin_prog();
            put(0, ins(7, 1));
            put(1, ins(2, 100));
            put(2, ins(1, 103));
            put(3, ins(1, 104));
            put(4, ins(7, 8));
            put(100, vals[i]);
            put(103, 12'd1);
            put(104, 12'd2);
            inc = vals[i] + 12'd1;
            run("R5");
            chk("R5", "incremented word", int'(mem[100]), int'(inc));
            chk("R5", "skip outcome", int'(dbg_ac), (inc == 0) ? 2 : 3);
        end

        // R7: subroutine call linkage
        begin_prog();
        put(0, ins(7, 1));
        put(1, ins(4, 50));
        put(2, ins(7, 8));
        put(51, ins(7, 4));
        put(52, ins(7, 8));
        run("R7");
        chk("R7", "link word", int'(mem[50]), 2);
        chk("R7", "ac in subroutine", int'(dbg_ac), 1);
        chk("R7", "pc after subroutine halt", int'(dbg_pc), 53);

        // R8: jump
        begin_prog();
        put(0, ins(5, 20));
        put(1, ins(7, 8));
        put(20, ins(7, 4));
        put(21, ins(7, 8));
        run("R8");
        chk("R8", "ac at jump target", int'(dbg_ac), 1);
        chk("R8", "pc after jump target halt", int'(dbg_pc), 22);

        // R10: device transfers, write then read
        begin_prog();
        put(0, ins(7, 1));
        put(1, ins(1, 100));
        put(2, ins(6, (6'h2A << 3)));
        put(3, ins(6, (6'h15 << 3) | 1));
        put(4, ins(7, 8));
        put(100, 12'h3C7);
        run("R10");
        chk("R10", "strobe cycles", strobes, 2);
        chk("R10", "last device code", int'(last_code), 6'h15);
        chk("R10", "ac from device", int'(dbg_ac), 12'h5A5);

        begin_prog();
        put(0, ins(7, 1));
        put(1, ins(1, 100));
        put(2, ins(6, (6'h2A << 3)));
        put(3, ins(7, 8));
        put(100, 12'h3C7);
        run("R10");
        chk("R10", "strobe cycles write only", strobes, 1);
        chk("R10", "device code", int'(last_code), 6'h2A);
        chk("R10", "device data", int'(last_out), 12'h3C7);
        chk("R10", "ac kept without read bit", int'(dbg_ac), 12'h3C7);

        // R11: frozen after halt
        repeat (10) @(negedge clk);
        chk("R11", "still halted", int'(halted), 1);
        chk("R11", "pc held", int'(dbg_pc), 4);
        chk("R11", "ac held", int'(dbg_ac), 12'h3C7);
        chk("R11", "no writes while halted", halt_writes, 0);

        // R1: reset from a halted, nonzero state
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "ac after reset", int'(dbg_ac), 0);
        chk("R1", "pc after reset", int'(dbg_pc), 0);
        chk("R1", "halted cleared", int'(halted), 0);

        // R12: read and write never together over all runs
        chk("R12", "read and write together", both_rw, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule